// File: doc/BRIEF.md
# Amplifier Mute and Fault Controller

This block decides whether the output stages of a pair of amplifier channels may switch. It takes already synchronized condition flags and combines them into a per-channel output enable, a hardware-mute flag, a low-power flag and a gain-reduction request. The flags cover supply over- and under-voltage, the two over-current thresholds, a missing speaker on each channel, the external mute and sleep pins, and the mute and sleep control bits. It also publishes fault and status vectors that a register file reads.

The fault causes behave in three ways. Supply faults clear themselves as soon as the condition goes away. An over-current shutdown stays latched until the mute pin changes level. A missing speaker holds the outputs off for as long as it lasts.

Releasing mute starts a fixed unmute delay, counted in pulses of a prescaled `tick` input. A silence timer, also counted in ticks, mutes the outputs once the summed input has stayed quiet for a selectable time, and releases them at once when the signal returns. Every output is registered, so each one reflects the inputs sampled at the previous clock edge.

Top module: `amp_mute_ctrl`

## Requirements
- R1: When `ov_i` or `uv_i` is high, the next cycle shows `out_en_o` all zero, `hw_mute_o` high and `fault_o[0]` high. One cycle after both go low, with no other cause present, the outputs are enabled again and `fault_o[0]` is low. There is no latch and no delay.
- R2: `oc_lim_i` high sets `gain_cut_o` on the next cycle and leaves `out_en_o` enabled.
- R3: `oc_sd_i` high disables the outputs and sets `fault_o[3]` on the next cycle. `fault_o[3]` stays set after `oc_sd_i` falls, and clears only in the cycle after `mute_pin_i` changes level (either edge) while `oc_sd_i` is low. `fault_o[2]` follows `oc_sd_i` with one cycle of delay.
- R4: While `mute_pin_i` or `mute_reg_i` is high, the outputs are off. After both fall, the outputs return only once UNMUTE_TICKS tick pulses have been sampled with the mute request low. A new mute request during that count restarts it.
- R5: If either bit of `spk_miss_i` is high, both outputs are off. The cycle after both bits are low, the outputs return, with no delay, however long the speaker was absent.
- R6: While `quiet_i` is high, tick pulses are counted. `stat_o[2]` rises, and the outputs turn off, once the count reaches the limit chosen by `sil_time_i`: 00 gives 4×SIL_UNIT_TICKS (reset choice), 01 gives SIL_UNIT_TICKS, 10 gives 8×SIL_UNIT_TICKS, and 11 disables the auto-mute.
- R7: When `quiet_i` falls, `stat_o[2]` drops and the silence mute releases on the next cycle. The silence count restarts from zero.
- R8: `sleep_pin_i` or `sleep_reg_i` high gives `low_power_o` high and both outputs off on the next cycle. The mute pin and the mute bit never set `low_power_o`.
- R9: `fault_o` bits: 0 is supply fault, 1 is always 0, 2 is over-current shutdown still present, 3 is latched over-current shutdown. `stat_o` bits: 0 is the OR of `fault_o`, 1 is muted for any cause (equal to `hw_mute_o`), 2 is silence mute.
- R10: During reset, `out_en_o` is 0, `hw_mute_o` is 1, `gain_cut_o` and `low_power_o` are 0, `fault_o` is 0 and `stat_o` is 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle time-base pulse from a prescaler |
| ov_i | input | 1 | Supply over-voltage |
| uv_i | input | 1 | Supply under-voltage |
| oc_lim_i | input | 1 | Over-current above the limiting threshold |
| oc_sd_i | input | 1 | Over-current above the shutdown threshold |
| spk_miss_i | input | NCH | Speaker not detected, one bit per channel |
| mute_pin_i | input | 1 | External mute pin |
| mute_reg_i | input | 1 | Mute control bit |
| sleep_pin_i | input | 1 | External sleep pin |
| sleep_reg_i | input | 1 | Sleep control bit |
| quiet_i | input | 1 | Summed input is below the silence level |
| sil_time_i | input | 2 | Silence duration code |
| out_en_o | output | NCH | Output-stage enable per channel |
| hw_mute_o | output | 1 | Outputs are muted |
| gain_cut_o | output | 1 | Request to reduce input gain |
| low_power_o | output | 1 | Low-power (sleep) indication |
| fault_o | output | 4 | Fault vector for the register file |
| stat_o | output | 3 | Status vector for the register file |

## Verification
The hardest case to reach from the ports is the restart of the unmute count. Mute has to be asserted again after a partial count, at a point where the ticks already seen plus the ticks still to come would exceed the delay if the count had not been reloaded. The stimulus times the reassertion against a free-running tick pattern so that this holds. The latched over-current clear is reached in a similar way: the mute pin is toggled well after `oc_sd_i` has fallen, so that the latch and the unmute delay overlap. Each silence code is held quiet for just under its limit and then past it, and a behavioural model compares every output on every clock.

// File: rtl/amp_mute_pkg.sv
package amp_mute_pkg;
  typedef enum logic [1:0] {
    SIL_X4  = 2'b00,
    SIL_X1  = 2'b01,
    SIL_X8  = 2'b10,
    SIL_OFF = 2'b11
  } sil_code_e;

  localparam int FLT_VOLT     = 0;
  localparam int FLT_RSVD     = 1;
  localparam int FLT_OC_LIVE  = 2;
  localparam int FLT_OC_LATCH = 3;
  localparam int FLT_W        = 4;

  localparam int ST_FAULT  = 0;
  localparam int ST_MUTED  = 1;
  localparam int ST_SILENT = 2;
  localparam int ST_W      = 3;
endpackage

// File: rtl/amp_oc_latch.sv
module amp_oc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic mute_pin_i,
  output logic held_next_o
);
  logic held_q;
  logic pin_q;
  logic toggled;

  assign toggled = mute_pin_i ^ pin_q;

  always_comb held_next_o = trip_i | (held_q & ~toggled);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      held_q <= held_next_o;
      pin_q  <= mute_pin_i;
    end
  end
endmodule

// File: rtl/amp_unmute_delay.sv
module amp_unmute_delay #(
  parameter int TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic req_i,
  output logic hold_next_o
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    if (req_i)
      cnt_n = LOAD;
    else if (tick_i && cnt_q != '0)
      cnt_n = cnt_q - 1'b1;
    else
      cnt_n = cnt_q;
    hold_next_o = (cnt_n != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/amp_silence_timer.sv
module amp_silence_timer
  import amp_mute_pkg::*;
#(
  parameter int UNIT = 85000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       quiet_i,
  input  logic [1:0] code_i,
  output logic       fire_next_o
);
  localparam int LIM_MAX = 8 * UNIT;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic [CW-1:0] lim;
  logic          armed;

  always_comb begin
    case (sil_code_e'(code_i))
      SIL_X1:  lim = CW'(UNIT);
      SIL_X8:  lim = CW'(LIM_MAX);
      default: lim = CW'(4 * UNIT);
    endcase
    armed = (sil_code_e'(code_i) != SIL_OFF) && quiet_i;
    if (!armed)
      cnt_n = '0;
    else if (tick_i && cnt_q < lim)
      cnt_n = cnt_q + 1'b1;
    else
      cnt_n = cnt_q;
    fire_next_o = armed && (cnt_n >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/amp_mute_ctrl.sv
module amp_mute_ctrl
  import amp_mute_pkg::*;
#(
  parameter int NCH            = 2,
  parameter int UNMUTE_TICKS   = 200,
  parameter int SIL_UNIT_TICKS = 85000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ov_i,
  input  logic             uv_i,
  input  logic             oc_lim_i,
  input  logic             oc_sd_i,
  input  logic [NCH-1:0]   spk_miss_i,
  input  logic             mute_pin_i,
  input  logic             mute_reg_i,
  input  logic             sleep_pin_i,
  input  logic             sleep_reg_i,
  input  logic             quiet_i,
  input  logic [1:0]       sil_time_i,
  output logic [NCH-1:0]   out_en_o,
  output logic             hw_mute_o,
  output logic             gain_cut_o,
  output logic             low_power_o,
  output logic [FLT_W-1:0] fault_o,
  output logic [ST_W-1:0]  stat_o
);
  logic volt_flt;
  logic oc_held_n;
  logic unmute_hold_n;
  logic sil_fire_n;
  logic sleep_req;
  logic mute_req;
  logic mute_any;
  logic [FLT_W-1:0] fault_n;
  logic [ST_W-1:0]  stat_n;

  assign volt_flt  = ov_i | uv_i;
  assign sleep_req = sleep_pin_i | sleep_reg_i;
  assign mute_req  = mute_pin_i | mute_reg_i;

  amp_oc_latch u_oc (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_i      (oc_sd_i),
    .mute_pin_i  (mute_pin_i),
    .held_next_o (oc_held_n)
  );

  amp_unmute_delay #(.TICKS(UNMUTE_TICKS)) u_dly (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .req_i       (mute_req),
    .hold_next_o (unmute_hold_n)
  );

  amp_silence_timer #(.UNIT(SIL_UNIT_TICKS)) u_sil (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .quiet_i     (quiet_i),
    .code_i      (sil_time_i),
    .fire_next_o (sil_fire_n)
  );

  always_comb begin
    mute_any = volt_flt | oc_held_n | (|spk_miss_i) | mute_req
             | unmute_hold_n | sil_fire_n | sleep_req;
    fault_n               = '0;
    fault_n[FLT_VOLT]     = volt_flt;
    fault_n[FLT_RSVD]     = 1'b0;
    fault_n[FLT_OC_LIVE]  = oc_sd_i;
    fault_n[FLT_OC_LATCH] = oc_held_n;
    stat_n            = '0;
    stat_n[ST_FAULT]  = |fault_n;
    stat_n[ST_MUTED]  = mute_any;
    stat_n[ST_SILENT] = sil_fire_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_mute_o   <= 1'b1;
      gain_cut_o  <= 1'b0;
      low_power_o <= 1'b0;
      fault_o     <= '0;
      stat_o      <= ST_W'(1 << ST_MUTED);
    end else begin
      hw_mute_o   <= mute_any;
      gain_cut_o  <= oc_lim_i;
      low_power_o <= sleep_req;
      fault_o     <= fault_n;
      stat_o      <= stat_n;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_en_o[g] <= 1'b0;
      else        out_en_o[g] <= ~mute_any;
    end
  end
endmodule

// File: rtl/amp_mute_ctrl_chk.sv
module amp_mute_ctrl_chk #(
  parameter int NCH          = 2,
  parameter int UNMUTE_TICKS = 200
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ov_i,
  input logic           uv_i,
  input logic           oc_lim_i,
  input logic           oc_sd_i,
  input logic [NCH-1:0] spk_miss_i,
  input logic           mute_pin_i,
  input logic           mute_reg_i,
  input logic           sleep_pin_i,
  input logic           sleep_reg_i,
  input logic           quiet_i,
  input logic [NCH-1:0] out_en_o,
  input logic           hw_mute_o,
  input logic           gain_cut_o,
  input logic           low_power_o,
  input logic [3:0]     fault_o,
  input logic [2:0]     stat_o
);
  p_volt_mute_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_i || uv_i) |=> (out_en_o == '0) && hw_mute_o && fault_o[0]);

  p_gain_cut_r2: assert property (@(posedge clk) disable iff (!rst_n)
    oc_lim_i |=> gain_cut_o);

  p_oc_shut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oc_sd_i |=> (out_en_o == '0) && fault_o[3] && fault_o[2]);

  p_oc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o[3] && !oc_sd_i && $stable(mute_pin_i)) |=> fault_o[3]);

  p_mute_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_pin_i || mute_reg_i) |=> hw_mute_o && (out_en_o == '0));

  p_unmute_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((UNMUTE_TICKS > 1) && $fell(mute_pin_i || mute_reg_i)) |=> hw_mute_o);

  p_spk_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|spk_miss_i) |=> (out_en_o == '0));

  p_quiet_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet_i |=> !stat_o[2]);

  p_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_pin_i || sleep_reg_i) |=> low_power_o && stat_o[1] && (out_en_o == '0));

  p_stat_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[0] == (|fault_o));
endmodule

bind amp_mute_ctrl amp_mute_ctrl_chk #(.NCH(NCH), .UNMUTE_TICKS(UNMUTE_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ov_i(ov_i), .uv_i(uv_i), .oc_lim_i(oc_lim_i),
  .oc_sd_i(oc_sd_i), .spk_miss_i(spk_miss_i), .mute_pin_i(mute_pin_i),
  .mute_reg_i(mute_reg_i), .sleep_pin_i(sleep_pin_i), .sleep_reg_i(sleep_reg_i),
  .quiet_i(quiet_i), .out_en_o(out_en_o), .hw_mute_o(hw_mute_o),
  .gain_cut_o(gain_cut_o), .low_power_o(low_power_o), .fault_o(fault_o),
  .stat_o(stat_o)
);

// File: tb/amp_mute_ctrl_test.sv
module amp_mute_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NCH   = 2;
  localparam int U     = 4;
  localparam int B     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic ov = 0, uv = 0, oc_lim = 0, oc_sd = 0;
  logic [NCH-1:0] spk = '0;
  logic mute_pin = 0, mute_reg = 0, sleep_pin = 0, sleep_reg = 0, quiet = 0;
  logic [1:0] code = 2'b00;
  logic [NCH-1:0] out_en;
  logic hw_mute, gain_cut, low_power;
  logic [3:0] fault;
  logic [2:0] stat;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  amp_mute_ctrl #(.NCH(NCH), .UNMUTE_TICKS(U), .SIL_UNIT_TICKS(B)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ov_i(ov), .uv_i(uv),
    .oc_lim_i(oc_lim), .oc_sd_i(oc_sd), .spk_miss_i(spk),
    .mute_pin_i(mute_pin), .mute_reg_i(mute_reg), .sleep_pin_i(sleep_pin),
    .sleep_reg_i(sleep_reg), .quiet_i(quiet), .sil_time_i(code),
    .out_en_o(out_en), .hw_mute_o(hw_mute), .gain_cut_o(gain_cut),
    .low_power_o(low_power), .fault_o(fault), .stat_o(stat)
  );

  // Behavioural reference model
  bit m_ocl, m_prev;
  int m_dly, m_sil;
  int e_en, e_hw, e_gain, e_lp, e_fault, e_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ocl = 0; m_prev = 0; m_dly = 0; m_sil = 0;
      e_en = 0; e_hw = 1; e_gain = 0; e_lp = 0; e_fault = 0; e_stat = 2;
    end else begin
      int lim;
      bit silent, any, volt;
      volt  = ov | uv;
      m_ocl = oc_sd || (m_ocl && (mute_pin == m_prev));
      m_prev = mute_pin;
      if (mute_pin || mute_reg) m_dly = U;
      else if (tick && m_dly > 0) m_dly = m_dly - 1;
      lim = (code == 2'b01) ? B : (code == 2'b10) ? 8*B : 4*B;
      if (code == 2'b11 || !quiet) m_sil = 0;
      else if (tick && m_sil < lim) m_sil = m_sil + 1;
      silent = (code != 2'b11) && quiet && (m_sil >= lim);
      any = volt || m_ocl || (spk != 0) || mute_pin || mute_reg || (m_dly > 0)
            || silent || sleep_pin || sleep_reg;
      e_en    = any ? 0 : (1 << NCH) - 1;
      e_hw    = any;
      e_gain  = oc_lim;
      e_lp    = sleep_pin || sleep_reg;
      e_fault = (m_ocl ? 8 : 0) + (oc_sd ? 4 : 0) + (volt ? 1 : 0);
      e_stat  = (silent ? 4 : 0) + (any ? 2 : 0) + ((e_fault != 0) ? 1 : 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(int'(out_en) == e_en, "R4 out_en vs model", int'(out_en), e_en);
    chk(int'(hw_mute) == e_hw, "R1 hw_mute vs model", int'(hw_mute), e_hw);
    chk(int'(gain_cut) == e_gain, "R2 gain_cut vs model", int'(gain_cut), e_gain);
    chk(int'(low_power) == e_lp, "R8 low_power vs model", int'(low_power), e_lp);
    chk(int'(fault) == e_fault, "R9 fault vs model", int'(fault), e_fault);
    chk(int'(stat) == e_stat, "R6 stat vs model", int'(stat), e_stat);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      if (rst_n) compare();
      tick = rst_n ? ~tick : 1'b0;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    step(3);
    // R10 reset values
    chk(out_en == 0, "R10 reset out_en", int'(out_en), 0);
    chk(hw_mute == 1, "R10 reset hw_mute", int'(hw_mute), 1);
    chk(fault == 0 && gain_cut == 0 && low_power == 0, "R10 reset flags", int'(fault), 0);
    chk(stat == 3'b010, "R10 reset stat", int'(stat), 2);
    rst_n = 1;
    step(3);
    chk(out_en == 2'b11, "R10 enabled after reset", int'(out_en), 3);

    // R1 supply faults, self-clearing
    ov = 1; step(3);
    chk(out_en == 0 && hw_mute == 1, "R1 ov mutes", int'(out_en), 0);
    chk(fault[0] == 1 && stat == 3'b011, "R1 R9 volt fault bits", int'(stat), 3);
    ov = 0; step(1);
    chk(out_en == 2'b11 && fault[0] == 0, "R1 ov clears", int'(out_en), 3);
    uv = 1; step(2); uv = 0; step(1);
    chk(out_en == 2'b11, "R1 uv clears", int'(out_en), 3);

    // R2 limiting keeps outputs on
    oc_lim = 1; step(2);
    chk(gain_cut == 1 && out_en == 2'b11, "R2 gain cut, enabled", int'(out_en), 3);
    oc_lim = 0; step(1);
    chk(gain_cut == 0, "R2 gain cut release", int'(gain_cut), 0);

    // R3 latched shutdown
    oc_sd = 1; step(2);
    chk(fault == 4'b1100 && out_en == 0, "R3 shutdown bits", int'(fault), 12);
    oc_sd = 0; step(20);
    chk(fault == 4'b1000 && out_en == 0, "R3 latch holds", int'(fault), 8);
    mute_pin = 1; step(1);
    chk(fault[3] == 0 && hw_mute == 1, "R3 toggle clears latch", int'(fault), 0);
    mute_pin = 0; step(1);
    chk(out_en == 0, "R4 delay after pin release", int'(out_en), 0);
    step(30);
    chk(out_en == 2'b11, "R4 unmute after delay", int'(out_en), 3);

    // R4 restart of the unmute count
    mute_reg = 1; step(2); mute_reg = 0; step(4);
    chk(out_en == 0, "R4 partial count", int'(out_en), 0);
    mute_reg = 1; step(1); mute_reg = 0; step(5);
    chk(out_en == 0, "R4 count restarted", int'(out_en), 0);
    step(20);
    chk(out_en == 2'b11, "R4 unmute after restart", int'(out_en), 3);

    // R5 speaker detect
    spk = 2'b01; step(50);
    chk(out_en == 0 && hw_mute == 1, "R5 ch0 missing", int'(out_en), 0);
    spk = 2'b00; step(1);
    chk(out_en == 2'b11, "R5 late detect recovers", int'(out_en), 3);
    spk = 2'b10; step(3);
    chk(out_en == 0, "R5 ch1 missing", int'(out_en), 0);
    spk = 2'b00; step(1);

    // R6 / R7 silence timer
    code = 2'b01; quiet = 1; step(2);
    chk(stat[2] == 0, "R6 short code not yet", int'(stat), 0);
    step(20);
    chk(stat[2] == 1 && out_en == 0, "R6 short code fires", int'(stat[2]), 1);
    quiet = 0; step(1);
    chk(stat[2] == 0 && out_en == 2'b11, "R7 quick unmute", int'(out_en), 3);
    code = 2'b11; quiet = 1; step(200);
    chk(stat[2] == 0 && out_en == 2'b11, "R6 disabled code", int'(stat[2]), 0);
    code = 2'b00; quiet = 0; step(1); quiet = 1; step(20);
    chk(stat[2] == 0, "R6 default code before limit", int'(stat[2]), 0);
    step(20);
    chk(stat[2] == 1, "R6 default code fires", int'(stat[2]), 1);
    quiet = 0; step(1); quiet = 1; step(3);
    chk(stat[2] == 0, "R7 count restarted", int'(stat[2]), 0);
    code = 2'b10; quiet = 0; step(1); quiet = 1; step(40);
    chk(stat[2] == 0, "R6 long code before limit", int'(stat[2]), 0);
    step(20);
    chk(stat[2] == 1, "R6 long code fires", int'(stat[2]), 1);
    quiet = 0; code = 2'b00; step(2);

    // R8 sleep
    sleep_pin = 1; step(1);
    chk(low_power == 1 && out_en == 0, "R8 sleep pin", int'(low_power), 1);
    sleep_pin = 0; sleep_reg = 1; step(1);
    chk(low_power == 1 && out_en == 0, "R8 sleep bit", int'(low_power), 1);
    sleep_reg = 0; step(1);
    chk(low_power == 0 && out_en == 2'b11, "R8 wake", int'(out_en), 3);
    mute_reg = 1; step(2);
    chk(low_power == 0 && out_en == 0, "R8 mute is not sleep", int'(low_power), 0);
    mute_reg = 0; step(20);

    // R9 status mapping
    oc_sd = 1; ov = 1; step(1);
    chk(fault == 4'b1101 && stat == 3'b011, "R9 combined bits", int'(fault), 13);
    oc_sd = 0; ov = 0; mute_pin = 1; step(1); mute_pin = 0; step(30);
    chk(fault == 0 && stat == 0 && out_en == 2'b11, "R9 all clear", int'(stat), 0);

    summary();
  end
endmodule